// File: doc/BRIEF.md
# Page-Mode DRAM Line-Fill Controller

This block sits between a cache's miss path and an asynchronous DRAM whose row and column addresses share one set of address pins. The cache hands it a line address and a direction. The controller opens the addressed row once by pulling the row strobe low. It then runs several column accesses on that open row, one per data beat, and closes the row with a precharge gap. A line of `BEATS` beats of `DATA_W` bits moves in a single row activation. Read beats go back to the cache as valid-qualified words, and the final beat carries a last flag. Write beats are pulled from the cache one at a time with a take pulse.

Every DRAM row must be read periodically to keep its contents. A built-in interval counter raises a refresh request at a fixed cycle spacing. The refresh is a row-strobe-only access to one row, and the row pointer steps through the whole array and wraps. All timing is given in whole clock cycles at elaboration: the row phase, the column phase and the precharge phase. Each phase reloads one down-counter.

Top module: `dram_line_ctrl`

## Requirements
- R1: While reset is held, the row, column, write-enable and output-enable strobes are all high (inactive), `rd_valid` and `wr_take` are 0 and the data bus is not driven.
- R2: `req_ready` is 1 only when the controller is idle and no refresh is pending. A request with `req_valid` high at such an edge is taken. In the next cycle the row strobe falls, and `dram_addr` carries the upper `ROW_W` bits of `req_line`, zero-extended.
- R3: The row strobe stays low without a break for `RAS_CYC` row cycles plus all `BEATS` column phases of a line. The column strobe is never low while the row strobe is high.
- R4: Each beat lasts `CAS_CYC` cycles. In the first cycle of a beat, the column strobe is high and the column address is set up. In the remaining cycles the strobe is low. The column address of beat n is the low bits of `req_line` times `BEATS` plus n, so beats run in increasing address order.
- R5: On a read, output enable is low and write enable is high through the column phases. In the last cycle of each beat, `rd_valid` is 1 and `rd_data` equals the DRAM data input. `rd_last` is 1 only on beat `BEATS-1`.
- R6: On a write, write enable is low, output enable is high and `dram_dq_oe` is 1 through the column phases, with `dram_dq_out` equal to `wr_data`. `wr_take` pulses in the last cycle of each beat, and `rd_valid` stays 0.
- R7: After each line or refresh, the row strobe stays high for at least `PRE_CYC` cycles before it falls again. This covers the part of the cycle time beyond the access time.
- R8: A refresh request is raised every `REF_PERIOD` cycles after reset. A refresh holds the row strobe low for `RAS_CYC` cycles with the column strobe, write enable and output enable high, and then precharges for `PRE_CYC` cycles.
- R9: Successive refreshes address rows 0, 1, 2, and so on. After row `REF_ROWS-1` the next refresh addresses row 0.
- R10: A refresh that becomes due during a line waits until that line's precharge ends. It then starts before any waiting cache request, and `req_ready` stays 0 until it is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write line, 0 = fill line |
| req_line | input | ROW_W+COL_W-log2(BEATS) | Line address: row bits above column bits |
| wr_data | input | DATA_W | Current write beat from the cache |
| wr_take | output | 1 | Current write beat consumed |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DATA_W | Read beat data |
| rd_last | output | 1 | Final beat of the line |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Write data to DRAM |
| dram_dq_oe | output | 1 | Drive enable for write data |
| dram_dq_in | input | DATA_W | Read data from DRAM |

## Verification
The embedded assertions check four rules on every cycle. The column strobe never falls outside an open row. Write and output enable are never low together. The precharge gap is always met, and the column address holds steady while the column strobe is low. They also check that no refresh tick lands on an unserved one, that the last flag only comes with valid data, and that the controller never offers to take a request while a refresh is pending. Only the bench's scenarios can show the beat timing, the column increments, and the data path against a behavioural memory. The same holds for the refresh row sweep through wrap-around and for the ordering when a refresh collides with a waiting read.

// File: rtl/dram_line_pkg.sv
package dram_line_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_PRE,
      ST_REF
   } ctl_state_t;

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int ROW_W      = 14,
   parameter int REF_ROWS   = 16384,
   parameter int REF_PERIOD = 61
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_start,
   input  logic             ref_done,
   output logic             ref_pend,
   output logic [ROW_W-1:0] ref_row
);
   localparam int IV_W = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;

   logic [IV_W-1:0] iv_cnt;
   logic            tick;

   assign tick = (iv_cnt == IV_W'(REF_PERIOD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iv_cnt   <= '0;
         ref_pend <= 1'b0;
      end else begin
         iv_cnt   <= tick ? '0 : iv_cnt + 1'b1;
         ref_pend <= tick | (ref_pend & ~ref_start);
      end
   end

   generate
      if ((1 << ROW_W) == REF_ROWS) begin : g_row_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)        ref_row <= '0;
            else if (ref_done) ref_row <= ref_row + 1'b1;
         end
      end else begin : g_row_cmp
         always_ff @(posedge clk) begin
            if (!rst_n) ref_row <= '0;
            else if (ref_done)
               ref_row <= (ref_row == ROW_W'(REF_ROWS - 1)) ? '0 : ref_row + 1'b1;
         end
      end
   endgenerate

   // R8
   no_lost_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> !ref_pend);

endmodule

// File: rtl/dram_phase_cnt.sv
module dram_phase_cnt #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_zero
);
   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign cnt_zero = (cnt == '0);

endmodule

// File: rtl/dram_addr_sel.sv
module dram_addr_sel
   import dram_line_pkg::*;
#(
   parameter int ROW_W  = 14,
   parameter int COL_W  = 14,
   parameter int ADDR_W = 14
) (
   input  ctl_state_t        st,
   input  logic [ROW_W-1:0]  line_row,
   input  logic [COL_W-1:0]  line_col,
   input  logic [ROW_W-1:0]  ref_row,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] row_x, col_x, ref_x;

   generate
      if (ROW_W == ADDR_W) begin : g_row_full
         assign row_x = line_row;
         assign ref_x = ref_row;
      end else begin : g_row_pad
         assign row_x = {{(ADDR_W-ROW_W){1'b0}}, line_row};
         assign ref_x = {{(ADDR_W-ROW_W){1'b0}}, ref_row};
      end
      if (COL_W == ADDR_W) begin : g_col_full
         assign col_x = line_col;
      end else begin : g_col_pad
         assign col_x = {{(ADDR_W-COL_W){1'b0}}, line_col};
      end
   endgenerate

   always_comb begin
      unique case (st)
         ST_ROW:  addr = row_x;
         ST_COL:  addr = col_x;
         ST_REF:  addr = ref_x;
         default: addr = '0;
      endcase
   end

endmodule

// File: rtl/dram_line_ctrl.sv
module dram_line_ctrl
   import dram_line_pkg::*;
#(
   parameter int ROW_W      = 14,
   parameter int COL_W      = 14,
   parameter int BEATS      = 4,
   parameter int DATA_W     = 64,
   parameter int RAS_CYC    = 5,
   parameter int CAS_CYC    = 2,
   parameter int PRE_CYC    = 3,
   parameter int REF_PERIOD = 61,
   parameter int REF_ROWS   = 16384,
   localparam int BEAT_W    = $clog2(BEATS),
   localparam int LINE_W    = ROW_W + COL_W - BEAT_W,
   localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [LINE_W-1:0] req_line,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_take,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic [ADDR_W-1:0] dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   localparam int LCOL_W  = COL_W - BEAT_W;
   localparam int MAX_A   = (RAS_CYC > CAS_CYC) ? RAS_CYC : CAS_CYC;
   localparam int MAX_CYC = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam int WORST   = 2 * RAS_CYC + BEATS * CAS_CYC + 2 * PRE_CYC;

   generate
      if (CAS_CYC < 2) begin : g_bad_cas
         $error("column phase needs at least two cycles");
      end
      if (RAS_CYC < 1 || PRE_CYC < 1) begin : g_bad_phase
         $error("row and precharge phases need at least one cycle");
      end
      if (BEATS < 2 || (1 << BEAT_W) != BEATS) begin : g_bad_beats
         $error("beat count must be a power of two of at least two");
      end
      if (REF_PERIOD <= WORST) begin : g_bad_ref
         $error("refresh period shorter than worst-case service delay");
      end
      if (REF_ROWS > (1 << ROW_W)) begin : g_bad_rows
         $error("refresh row count exceeds the row address range");
      end
   endgenerate

   ctl_state_t         st, st_nxt;
   logic [ROW_W-1:0]   lat_row;
   logic [LCOL_W-1:0]  lat_col;
   logic               lat_wr;
   logic [BEAT_W-1:0]  beat;
   logic               ph_load;
   logic [CNT_W-1:0]   ph_val;
   logic [CNT_W-1:0]   ph_cnt;
   logic               ph_zero;
   logic               accept, ref_go, ref_fin, beat_inc, beat_clr;
   logic               ref_pend;
   logic [ROW_W-1:0]   ref_row;
   logic               beat_end;

   dram_refresh_sched #(
      .ROW_W(ROW_W), .REF_ROWS(REF_ROWS), .REF_PERIOD(REF_PERIOD)
   ) refresh_i (
      .clk(clk), .rst_n(rst_n), .ref_start(ref_go), .ref_done(ref_fin),
      .ref_pend(ref_pend), .ref_row(ref_row)
   );

   dram_phase_cnt #(.CNT_W(CNT_W)) phase_i (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
      .cnt(ph_cnt), .cnt_zero(ph_zero)
   );

   dram_addr_sel #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) addr_i (
      .st(st), .line_row(lat_row), .line_col({lat_col, beat}),
      .ref_row(ref_row), .addr(dram_addr)
   );

   always_comb begin
      st_nxt   = st;
      ph_load  = 1'b0;
      ph_val   = '0;
      accept   = 1'b0;
      ref_go   = 1'b0;
      ref_fin  = 1'b0;
      beat_inc = 1'b0;
      beat_clr = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (ref_pend) begin
               st_nxt  = ST_REF;
               ph_load = 1'b1;
               ph_val  = CNT_W'(RAS_CYC - 1);
               ref_go  = 1'b1;
            end else if (req_valid) begin
               st_nxt  = ST_ROW;
               ph_load = 1'b1;
               ph_val  = CNT_W'(RAS_CYC - 1);
               accept  = 1'b1;
            end
         end
         ST_ROW: begin
            if (ph_zero) begin
               st_nxt   = ST_COL;
               ph_load  = 1'b1;
               ph_val   = CNT_W'(CAS_CYC - 1);
               beat_clr = 1'b1;
            end
         end
         ST_COL: begin
            if (ph_zero) begin
               ph_load = 1'b1;
               if (beat == BEAT_W'(BEATS - 1)) begin
                  st_nxt = ST_PRE;
                  ph_val = CNT_W'(PRE_CYC - 1);
               end else begin
                  beat_inc = 1'b1;
                  ph_val   = CNT_W'(CAS_CYC - 1);
               end
            end
         end
         ST_REF: begin
            if (ph_zero) begin
               st_nxt  = ST_PRE;
               ph_load = 1'b1;
               ph_val  = CNT_W'(PRE_CYC - 1);
               ref_fin = 1'b1;
            end
         end
         ST_PRE: begin
            if (ph_zero) st_nxt = ST_IDLE;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         beat    <= '0;
         lat_row <= '0;
         lat_col <= '0;
         lat_wr  <= 1'b0;
      end else begin
         st <= st_nxt;
         if (beat_clr)      beat <= '0;
         else if (beat_inc) beat <= beat + 1'b1;
         if (accept) begin
            lat_row <= req_line[LINE_W-1 -: ROW_W];
            lat_col <= req_line[LCOL_W-1:0];
            lat_wr  <= req_write;
         end
      end
   end

   assign req_ready   = (st == ST_IDLE) && !ref_pend;
   assign beat_end    = (st == ST_COL) && ph_zero;
   assign dram_ras_n  = !((st == ST_ROW) || (st == ST_COL) || (st == ST_REF));
   assign dram_cas_n  = !((st == ST_COL) && (ph_cnt != CNT_W'(CAS_CYC - 1)));
   assign dram_we_n   = !((st == ST_COL) && lat_wr);
   assign dram_oe_n   = !((st == ST_COL) && !lat_wr);
   assign dram_dq_oe  = (st == ST_COL) && lat_wr;
   assign dram_dq_out = wr_data;
   assign wr_take     = beat_end && lat_wr;
   assign rd_valid    = beat_end && !lat_wr;
   assign rd_data     = dram_dq_in;
   assign rd_last     = rd_valid && (beat == BEAT_W'(BEATS - 1));

   // precharge gap tracker for the R7 check
   logic [CNT_W-1:0] hi_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                                 hi_cnt <= CNT_W'(PRE_CYC);
      else if (!dram_ras_n)                       hi_cnt <= '0;
      else if (hi_cnt != CNT_W'(PRE_CYC))         hi_cnt <= hi_cnt + 1'b1;
   end

   // R3
   cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);
   // R6
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dram_we_n && !dram_oe_n));
   // R6
   drive_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> (!dram_we_n && dram_oe_n));
   // R7
   precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (hi_cnt >= CNT_W'(PRE_CYC)));
   // R4
   col_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));
   // R5
   last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);
   // R10
   no_take_during_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !ref_pend);

endmodule

// File: tb/dram_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_line_ctrl_tb_top;
   localparam int RW = 4, CW = 5, NB = 4, DW = 64;
   localparam int RAS = 5, CAS = 2, PRE = 3, RP = 40, NROWS = 16;
   localparam int LW = RW + CW - 2;
   localparam int AW = 5;
   localparam int LINE_T = RAS + NB * CAS + PRE;
   localparam int REF_T  = RAS + PRE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [LW-1:0] req_line = '0;
   logic [DW-1:0] wr_data, rd_data, dq_out, dq_in;
   logic req_ready, wr_take, rd_valid, rd_last, ras_n, cas_n, we_n, oe_n, dq_oe;
   logic [AW-1:0] addr;

   always #4 clk = ~clk;

   dram_line_ctrl #(
      .ROW_W(RW), .COL_W(CW), .BEATS(NB), .DATA_W(DW), .RAS_CYC(RAS),
      .CAS_CYC(CAS), .PRE_CYC(PRE), .REF_PERIOD(RP), .REF_ROWS(NROWS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_line(req_line), .wr_data(wr_data),
      .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_last(rd_last), .dram_addr(addr), .dram_ras_n(ras_n),
      .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
      .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
   );

   // behavioural DRAM
   logic [DW-1:0] mem    [0:(1<<(RW+CW))-1];
   logic [DW-1:0] shadow [0:(1<<(RW+CW))-1];
   logic [RW-1:0] open_row = '0;
   logic          ras_prev = 1'b1;
   initial begin
      for (int i = 0; i < (1<<(RW+CW)); i++) begin
         mem[i]    = {32'(i) * 32'h9E37, 32'(i) ^ 32'hA5A5_0F0F};
         shadow[i] = mem[i];
      end
   end
   assign dq_in = mem[{open_row, addr[CW-1:0]}];
   always @(posedge clk) begin
      ras_prev <= ras_n;
      if (!ras_n && ras_prev) open_row <= addr[RW-1:0];
      if (!cas_n && !we_n) mem[{open_row, addr[CW-1:0]}] <= dq_out;
   end

   // cache-side write buffer
   logic [DW-1:0] wbuf [0:NB-1];
   int widx = 0;
   assign wr_data = wbuf[widx[1:0]];
   always @(posedge clk) begin
      if (req_valid && req_ready) widx <= 0;
      else if (wr_take)           widx <= widx + 1;
   end

   // reference model: 0 idle, 1 line, 2 refresh
   int m_op, m_t, m_wr, m_row, m_col, m_rcnt, m_pend, m_rrow, m_refs;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_op = 0; m_t = 0; m_pend = 0; m_rcnt = 0; m_rrow = 0; m_refs = 0;
      end else begin
         int tick, rel;
         tick = (m_rcnt == RP - 1);
         m_rcnt = tick ? 0 : m_rcnt + 1;
         if (m_op == 0) begin
            if (m_pend) begin
               m_op = 2; m_t = 0; m_pend = 0; m_refs++;
            end else if (req_valid) begin
               m_op = 1; m_t = 0; m_wr = req_write;
               m_row = int'(req_line) >> (CW - 2);
               m_col = int'(req_line) & ((1 << (CW - 2)) - 1);
            end
         end else begin
            rel = m_t - RAS;
            if (m_op == 1 && m_wr && rel >= 0 && rel < NB * CAS && rel % CAS == CAS - 1)
               shadow[m_row * (1 << CW) + m_col * NB + rel / CAS] = wbuf[rel / CAS];
            m_t++;
            if (m_op == 1 && m_t == LINE_T) m_op = 0;
            if (m_op == 2 && m_t == REF_T) begin
               m_op = 0; m_rrow = (m_rrow + 1) % NROWS;
            end
         end
         if (tick) m_pend = 1;
      end
   end

   int total = 0, bad = 0;
   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         logic e_ras, e_cas, e_we, e_oe, e_rv, e_last, e_wt, e_oe_dq, e_rdy;
         logic [AW-1:0] e_addr;
         logic [DW-1:0] e_data;
         int b, k, rel;
         string areq;
         e_ras = 1; e_cas = 1; e_we = 1; e_oe = 1; e_rv = 0; e_last = 0;
         e_wt = 0; e_oe_dq = 0; e_addr = '0; e_data = '0; areq = "R4";
         e_rdy = (m_op == 0) && !m_pend;
         rel = m_t - RAS;
         if (m_op == 1) begin
            if (m_t < RAS) begin
               e_ras = 0; e_addr = AW'(m_row); areq = "R2";
            end else if (rel < NB * CAS) begin
               b = rel / CAS; k = rel % CAS;
               e_ras = 0; e_cas = (k == 0); e_addr = AW'(m_col * NB + b);
               if (m_wr) begin
                  e_we = 0; e_oe_dq = 1; e_wt = (k == CAS - 1); e_data = wbuf[b];
               end else begin
                  e_oe = 0; e_rv = (k == CAS - 1); e_last = e_rv && (b == NB - 1);
                  e_data = shadow[m_row * (1 << CW) + m_col * NB + b];
               end
            end
         end else if (m_op == 2 && m_t < RAS) begin
            e_ras = 0; e_addr = AW'(m_rrow); areq = "R9";
         end
         chk(ras_n == e_ras, (m_op == 2) ? "R8" : "R3", "row strobe", DW'(ras_n), DW'(e_ras));
         chk(cas_n == e_cas, "R4", "column strobe", DW'(cas_n), DW'(e_cas));
         chk(addr == e_addr, areq, "address", DW'(addr), DW'(e_addr));
         chk(we_n == e_we && oe_n == e_oe, "R5", "we/oe", DW'({we_n, oe_n}), DW'({e_we, e_oe}));
         chk(req_ready == e_rdy, "R10", "req_ready", DW'(req_ready), DW'(e_rdy));
         chk(rd_valid == e_rv && rd_last == e_last, "R5", "rd_valid/last",
             DW'({rd_valid, rd_last}), DW'({e_rv, e_last}));
         if (e_rv) chk(rd_data == e_data, "R5", "read data", rd_data, e_data);
         chk(wr_take == e_wt && dq_oe == e_oe_dq, "R6", "take/drive",
             DW'({wr_take, dq_oe}), DW'({e_wt, e_oe_dq}));
         if (e_oe_dq) chk(dq_out == e_data, "R6", "write data", dq_out, e_data);
      end
   end

   task automatic issue(input bit wr, input int line, input int seed);
      @(negedge clk); #1;
      if (wr) begin
         while (!req_ready) begin @(negedge clk); #1; end
         for (int k = 0; k < NB; k++) wbuf[k] = {32'(seed), 32'(k * 7 + 1)};
      end
      req_valid = 1'b1; req_write = wr; req_line = LW'(line);
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   initial begin
      for (int k = 0; k < NB; k++) wbuf[k] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes in reset",
          DW'({ras_n, cas_n, we_n, oe_n}), DW'(4'hF));
      chk(!rd_valid && !wr_take && !dq_oe, "R1", "outputs in reset",
          DW'({rd_valid, wr_take, dq_oe}), '0);
      #1 rst_n = 1'b1;
      issue(1, 3, 32'h1111);
      issue(0, 3, 0);
      issue(1, (1 << LW) - 1, 32'h2222);
      issue(0, (1 << LW) - 1, 0);
      issue(0, 40, 0);
      for (int i = 0; i < 24; i++) issue(i % 3 == 0, (i * 37 + 5) % (1 << LW), 32'h3000 + i);
      issue(0, 3, 0);
      repeat (RP * NROWS + 50) @(negedge clk);
      // R9: sweep passed the wrap point
      chk(m_refs > NROWS, "R9", "refresh count", DW'(m_refs), DW'(NROWS + 1));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule